// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Bus Clock Generator

This block derives two bus clock phases and a peripheral enable from a fast free-running reference clock. Each machine cycle has a fixed order. Phase 1 goes high first and marks the part of the cycle where the address is driven. After a dead time, phase 2 goes high and marks the data-transfer window. A second dead time follows, and then the cycle closes. The two phases are never high together. The peripheral enable is not a clock of its own: it copies phase 2 cycle for cycle.

All timing is set in reference-clock ticks. Four parameters give the cycle length, the width of each phase and the dead time, so one design covers the standard 1 µs cycle, the faster 666 ns and 500 ns cycles, and long cycles down to a 0.1 MHz bus rate. Parameter sets that cannot fit are rejected when the design is elaborated. A synchronous run input freezes the generator where it stands, and clearing it again lets the cycle continue from that point. All three outputs are driven directly from flops, so they do not glitch.

Top module: `biphase_clkgen`

## Requirements
- R1: The phase-1 output and the phase-2 output are never both high in the same reference cycle.
- R2: While the reset input is low, phase 1, phase 2 and the peripheral enable are all low, and they go low as soon as reset is asserted, without waiting for a clock edge.
- R3: Reset release is synchronised to the reference clock. With run held high, the outputs stay low for two reference edges after release, and the third edge raises phase 1 before phase 2 rises.
- R4: With run high, each cycle starts with phase 1 high for exactly PH1_TICKS reference ticks.
- R5: After phase 1 falls, both phases stay low for exactly GAP_TICKS ticks. Phase 2 then stays high for exactly PH2_TICKS ticks.
- R6: After phase 2 falls, both phases stay low for the rest of the cycle, which is at least GAP_TICKS ticks. Phase 1 rises again CYCLE_TICKS ticks after its previous rise.
- R7: The peripheral enable has the same value as phase 2 in every reference cycle.
- R8: When run is low at a reference edge, all outputs and the position within the cycle hold. When run returns high, the sequence continues from the held position, so a pause only lengthens the phase that was active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| run | input | 1 | Synchronous clock enable; low freezes the generator |
| phi1 | output | 1 | Bus phase 1, the address-output part of the cycle |
| phi2 | output | 1 | Bus phase 2, the data-transfer part of the cycle |
| periph_en | output | 1 | Peripheral enable, a copy of phase 2 |

## Verification
The bench builds the block with a 12-tick cycle, 4-tick phase 1, 3-tick phase 2 and 2-tick dead time. These values leave a 3-tick tail after phase 2, so the tail and the middle gap can be told apart. A full cycle takes only a handful of steps, so one vector table can reach the cycle wrap, repeated wraps, and pauses placed inside phase 1 and inside phase 2. Because the dead time is more than one tick, a gap that is off by one shows up at the outputs.

// File: rtl/biphase_clkgen_pkg.sv
package biphase_clkgen_pkg;

  typedef struct packed {
    logic ph1;
    logic ph2;
  } phase_pair_t;

endpackage

// File: rtl/bcg_rst_sync.sv
module bcg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;

endmodule

// File: rtl/bcg_tick_counter.sv
module bcg_tick_counter #(
  parameter int CYCLE = 100,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] pos
);

  localparam logic [CW-1:0] LAST = CW'(CYCLE - 1);

  logic [CW-1:0] pos_q;
  logic [CW-1:0] pos_nx;

  always_comb begin
    pos_nx = pos_q;
    if (en) begin
      if (pos_q == LAST) pos_nx = '0;
      else               pos_nx = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_nx;
  end

  assign pos = pos_q;

endmodule

// File: rtl/bcg_phase_decode.sv
module bcg_phase_decode
  import biphase_clkgen_pkg::*;
#(
  parameter int PH1 = 45,
  parameter int PH2 = 45,
  parameter int GAP = 5,
  parameter int CW  = 7
) (
  input  logic [CW-1:0] pos,
  output phase_pair_t   phase
);

  localparam logic [CW-1:0] P1_END = CW'(PH1);
  localparam logic [CW-1:0] P2_BEG = CW'(PH1 + GAP);
  localparam logic [CW-1:0] P2_END = CW'(PH1 + GAP + PH2);

  always_comb begin
    phase.ph1 = (pos < P1_END);
    phase.ph2 = (pos >= P2_BEG) && (pos < P2_END);
  end

endmodule

// File: rtl/biphase_clkgen.sv
module biphase_clkgen
  import biphase_clkgen_pkg::*;
#(
  parameter int CYCLE_TICKS = 100,
  parameter int PH1_TICKS   = 45,
  parameter int PH2_TICKS   = 45,
  parameter int GAP_TICKS   = 5
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic run,
  output logic phi1,
  output logic phi2,
  output logic periph_en
);

  localparam int CW = (CYCLE_TICKS > 2) ? $clog2(CYCLE_TICKS) : 1;

  generate
    if (GAP_TICKS < 1) begin : g_bad_gap
      $error("biphase_clkgen: dead time must be at least one tick");
    end
    if (PH1_TICKS < 1 || PH2_TICKS < 1) begin : g_bad_width
      $error("biphase_clkgen: phase widths must be at least one tick");
    end
    if (PH1_TICKS + PH2_TICKS + 2 * GAP_TICKS > CYCLE_TICKS) begin : g_bad_fit
      $error("biphase_clkgen: widths plus two dead times exceed the cycle");
    end
  endgenerate

  logic          srst_n;
  logic [CW-1:0] pos;
  phase_pair_t   dec;
  phase_pair_t   ph_q;
  phase_pair_t   ph_nx;
  logic          pe_q;
  logic          pe_nx;

  bcg_rst_sync u_rst_sync (
    .clk    (clk_ref),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  bcg_tick_counter #(
    .CYCLE (CYCLE_TICKS),
    .CW    (CW)
  ) u_counter (
    .clk   (clk_ref),
    .rst_n (srst_n),
    .en    (run),
    .pos   (pos)
  );

  bcg_phase_decode #(
    .PH1 (PH1_TICKS),
    .PH2 (PH2_TICKS),
    .GAP (GAP_TICKS),
    .CW  (CW)
  ) u_decode (
    .pos   (pos),
    .phase (dec)
  );

  always_comb begin
    ph_nx = ph_q;
    pe_nx = pe_q;
    if (run) begin
      ph_nx = dec;
      pe_nx = dec.ph2;
    end
  end

  always_ff @(posedge clk_ref or negedge srst_n) begin
    if (!srst_n) begin
      ph_q <= '0;
      pe_q <= 1'b0;
    end else begin
      ph_q <= ph_nx;
      pe_q <= pe_nx;
    end
  end

  assign phi1      = ph_q.ph1;
  assign phi2      = ph_q.ph2;
  assign periph_en = pe_q;

endmodule

// File: rtl/biphase_clkgen_chk.sv
module biphase_clkgen_chk #(
  parameter int PH1_TICKS = 45,
  parameter int PH2_TICKS = 45,
  parameter int GAP_TICKS = 5
) (
  input logic clk_ref,
  input logic rst_n,
  input logic run,
  input logic phi1,
  input logic phi2,
  input logic periph_en
);

  logic [15:0] hi1_q;
  logic [15:0] hi2_q;
  logic [15:0] low_q;
  logic        seen_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      hi1_q  <= '0;
      hi2_q  <= '0;
      low_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      hi1_q  <= phi1 ? ((hi1_q == 16'hFFFF) ? hi1_q : hi1_q + 1'b1) : '0;
      hi2_q  <= phi2 ? ((hi2_q == 16'hFFFF) ? hi2_q : hi2_q + 1'b1) : '0;
      low_q  <= (phi1 || phi2) ? '0 : ((low_q == 16'hFFFF) ? low_q : low_q + 1'b1);
      seen_q <= seen_q || phi1 || phi2;
    end
  end

  // R1
  no_overlap_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !(phi1 && phi2));

  // R7
  enable_follows_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    periph_en == phi2);

  // R4
  ph1_width_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(phi1) |-> (hi1_q >= 16'(PH1_TICKS)));

  // R5
  ph2_width_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(phi2) |-> (hi2_q >= 16'(PH2_TICKS)));

  // R6
  dead_time_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (seen_q && ($rose(phi1) || $rose(phi2))) |-> (low_q >= 16'(GAP_TICKS)));

  // R8
  pause_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !run |=> ($stable(phi1) && $stable(phi2) && $stable(periph_en)));

  // R2
  reset_low_chk: assert property (@(posedge clk_ref)
    !rst_n |-> (!phi1 && !phi2 && !periph_en));

endmodule

bind biphase_clkgen biphase_clkgen_chk #(
  .PH1_TICKS (PH1_TICKS),
  .PH2_TICKS (PH2_TICKS),
  .GAP_TICKS (GAP_TICKS)
) u_chk (
  .clk_ref   (clk_ref),
  .rst_n     (rst_n),
  .run       (run),
  .phi1      (phi1),
  .phi2      (phi2),
  .periph_en (periph_en)
);

// File: tb/biphase_clkgen_tb.sv
module biphase_clkgen_tb;

  localparam int CYC = 12;
  localparam int P1  = 4;
  localparam int P2  = 3;
  localparam int GP  = 2;

  logic clk_ref;
  logic rst_n;
  logic run;
  logic phi1;
  logic phi2;
  logic periph_en;

  int errors;
  int checks;
  int k;

  biphase_clkgen #(
    .CYCLE_TICKS (CYC),
    .PH1_TICKS   (P1),
    .PH2_TICKS   (P2),
    .GAP_TICKS   (GP)
  ) u_dut (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .run       (run),
    .phi1      (phi1),
    .phi2      (phi2),
    .periph_en (periph_en)
  );

  initial clk_ref = 1'b0;
  always #2 clk_ref = ~clk_ref;

  // {run, steps[6:0], expected phi1, expected phi2} after the steps
  localparam logic [9:0] VEC [0:11] = '{
    {1'b1, 7'd1,  1'b1, 1'b0},
    {1'b1, 7'd3,  1'b1, 1'b0},
    {1'b1, 7'd1,  1'b0, 1'b0},
    {1'b1, 7'd2,  1'b0, 1'b1},
    {1'b0, 7'd5,  1'b0, 1'b1},
    {1'b1, 7'd2,  1'b0, 1'b1},
    {1'b1, 7'd1,  1'b0, 1'b0},
    {1'b1, 7'd3,  1'b1, 1'b0},
    {1'b0, 7'd3,  1'b1, 1'b0},
    {1'b1, 7'd6,  1'b0, 1'b1},
    {1'b1, 7'd12, 1'b0, 1'b1},
    {1'b1, 7'd5,  1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {phi1,phi2,pe} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] model(input int n);
    int c;
    logic a;
    logic b;
    if (n == 0) return 3'b000;
    c = (n - 1) % CYC;
    a = (c < P1);
    b = (c >= P1 + GP) && (c < P1 + GP + P2);
    return {a, b, b};
  endfunction

  function automatic string region(input int n);
    int c;
    c = (n - 1) % CYC;
    if (c < P1) return "R4";
    if (c < P1 + GP + P2) return "R5";
    return "R6";
  endfunction

  task automatic step(input logic r);
    @(negedge clk_ref);
    run = r;
    @(posedge clk_ref);
    #1;
    if (r) k++;
    chk(r ? region(k) : "R8", {phi1, phi2, periph_en}, model(k));
    chk("R1", {1'b0, phi1 & phi2, 1'b0}, 3'b000);
    chk("R7", {2'b00, periph_en}, {2'b00, phi2});
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors = 0;
    checks = 0;
    k = 0;
    rst_n = 1'b0;
    run = 1'b0;
    repeat (3) @(posedge clk_ref);
    #1;
    chk("R2", {phi1, phi2, periph_en}, 3'b000);
    @(negedge clk_ref);
    rst_n = 1'b1;
    repeat (3) begin
      @(posedge clk_ref);
      #1;
      chk("R2", {phi1, phi2, periph_en}, 3'b000);
    end

    for (int i = 0; i < 12; i++) begin
      for (int s = 0; s < int'(VEC[i][8:2]); s++) step(VEC[i][9]);
      chk(VEC[i][9] ? "R6" : "R8", {phi1, phi2, periph_en},
          {VEC[i][1], VEC[i][0], VEC[i][0]});
    end

    // asynchronous reset in the middle of phase 2
    while (!phi2) step(1'b1);
    @(negedge clk_ref);
    rst_n = 1'b0;
    #1;
    chk("R2", {phi1, phi2, periph_en}, 3'b000);
    @(negedge clk_ref);
    rst_n = 1'b1;
    run = 1'b1;
    @(posedge clk_ref);
    #1;
    chk("R3", {phi1, phi2, periph_en}, 3'b000);
    @(posedge clk_ref);
    #1;
    chk("R3", {phi1, phi2, periph_en}, 3'b000);
    @(posedge clk_ref);
    #1;
    chk("R3", {phi1, phi2, periph_en}, 3'b100);
    k = 1;

    // pause inside the dead time, then one full cycle plus a wrap
    for (int s = 0; s < P1; s++) step(1'b1);
    for (int s = 0; s < 4; s++) step(1'b0);
    for (int s = 0; s < CYC + 2; s++) step(1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule